// File: doc/BRIEF.md
# Monochrome VGA Scanout with Active-Window Framing

This block produces 640x480 VGA raster timing from a system clock and a pixel-rate clock enable. It drives active-low horizontal and vertical sync, a one-bit pixel output, and a framing strobe that is high over the whole non-visible part of every line. Pixels come from a frame buffer through a byte-wide synchronous read port with one clock of read latency. Each byte holds eight pixels, and the most significant bit is shown first.

The horizontal counter starts at the front porch. The framing strobe covers the front porch, the sync pulse and the back porch. Because of this, the pixel shifter runs only across the visible span, and the frame buffer holds visible pixels and nothing else. The read address is loaded from a base input once per frame, at the first tick of the frame. After that it steps through every line with no gaps. The block prefetches each byte eight pixels before it is needed, which hides the read latency. The line and pixel counters and an active-video flag are exported.

All timing figures are parameters. The defaults are 640 active pixels, a 16/96/48 horizontal front porch, sync and back porch, 480 active lines, and a 10/2/33 vertical front porch, sync and back porch. The active width must be a multiple of 8.

Top module: `vga_mono_scanout`

## Requirements
- R1: On each cycle with `pixEn` high, `hCount` advances by one. It wraps from 799 to 0, so a line is 800 ticks (total = front porch + sync + back porch + active).
- R2: `vCount` advances only on the tick where `hCount` wraps. It wraps from 524 to 0, so a frame is 525 lines. Vertical line 0 is the first line of the vertical front porch.
- R3: `hSyncN` is 0 exactly while 16 <= `hCount` < 112 (front porch through front porch + sync), and 1 otherwise.
- R4: `vSyncN` is 0 exactly while 10 <= `vCount` < 12, and 1 otherwise.
- R5: `frameStrobe` is 1 exactly while `hCount` < 160 (porches plus sync), and 0 for the rest of the line.
- R6: `activeVideo` is 1 exactly when `hCount` >= 160 and `vCount` >= 45.
- R7: While `activeVideo` is 1, `pixOut` is bit 7-(p mod 8) of the byte at address B + L*80 + p/8. Here p = `hCount`-160, L = `vCount`-45, and B is the base captured for the current frame.
- R8: While `activeVideo` is 0, `pixOut` is 0.
- R9: `baseAddr` is sampled only on the tick where `hCount` = 0 and `vCount` = 0, and at reset. A change at any other time has no effect on the pixels of the current frame.
- R10: While `pixEn` is low, the counters, the sync outputs and `pixOut` hold their values.
- R11: A synchronous reset sets `hCount` and `vCount` to 0 and sets the read address to `baseAddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pixEn | input | 1 | Pixel-rate clock enable |
| baseAddr | input | ADDR_W | Frame base address in the frame buffer |
| memAddr | output | ADDR_W | Frame buffer read address |
| memData | input | 8 | Read data, valid one clock after the address |
| hSyncN | output | 1 | Horizontal sync, active low |
| vSyncN | output | 1 | Vertical sync, active low |
| frameStrobe | output | 1 | High across porches and sync of each line |
| pixOut | output | 1 | Monochrome pixel |
| activeVideo | output | 1 | Visible-window flag |
| hCount | output | clog2(line total) | Pixel counter within the line |
| vCount | output | clog2(frame total) | Line counter within the frame |

## Verification
Two events can land in the same cycle: the frame-start tick that reloads the read address from `baseAddr`, and a change of `baseAddr` itself. A `pixEn` drop can also coincide with the tick that loads a prefetched byte. A scaled-down instance runs through dozens of frames. On every cycle it has a random enable and occasional random base changes, so both collisions occur many times. Each pixel is checked against a memory image indexed by the base captured by an independent bench model. A second instance at the default timing is checked for exact sync and strobe edges and for the first visible line.

// File: rtl/vga_scan_pkg.sv
package vga_scan_pkg;
  // Strobes handed from the raster control to the pixel datapath
  typedef struct packed {
    logic loadBase;  // reload read address from the frame base
    logic loadByte;  // take prefetched byte into the shifter, step address
    logic shiftBit;  // advance the shifter by one pixel
    logic active;    // inside the visible window
  } scanStrb_t;
endpackage

// File: rtl/vga_scan_ctrl.sv
module vga_scan_ctrl
  import vga_scan_pkg::*;
#(
  parameter int H_ACT  = 640,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_ACT  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33,
  localparam int H_START = H_FP + H_SYNC + H_BP,
  localparam int H_TOTAL = H_START + H_ACT,
  localparam int V_START = V_FP + V_SYNC + V_BP,
  localparam int V_TOTAL = V_START + V_ACT,
  localparam int HW = $clog2(H_TOTAL),
  localparam int VW = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pixEn,
  output logic [HW-1:0] hCount,
  output logic [VW-1:0] vCount,
  output logic          hSyncN,
  output logic          vSyncN,
  output logic          frameStrobe,
  output scanStrb_t     strb
);
  localparam logic [HW-1:0] H_LAST    = HW'(H_TOTAL - 1);
  localparam logic [HW-1:0] H_PRELOAD = HW'(H_START - 1);
  localparam logic [HW-1:0] H_STARTC  = HW'(H_START);
  localparam logic [HW-1:0] HS_ON     = HW'(H_FP);
  localparam logic [HW-1:0] HS_OFF    = HW'(H_FP + H_SYNC);
  localparam logic [VW-1:0] V_LAST    = VW'(V_TOTAL - 1);
  localparam logic [VW-1:0] V_STARTC  = VW'(V_START);
  localparam logic [VW-1:0] VS_ON     = VW'(V_FP);
  localparam logic [VW-1:0] VS_OFF    = VW'(V_FP + V_SYNC);

  logic          lineVis;
  logic          inWin;
  logic [HW-1:0] hOff;

  always_ff @(posedge clk) begin
    if (rst) begin
      hCount <= '0;
      vCount <= '0;
    end else if (pixEn) begin
      if (hCount == H_LAST) begin
        hCount <= '0;
        vCount <= (vCount == V_LAST) ? '0 : vCount + 1'b1;
      end else begin
        hCount <= hCount + 1'b1;
      end
    end
  end

  assign lineVis     = (vCount >= V_STARTC);
  assign inWin       = lineVis && (hCount >= H_STARTC);
  assign hOff        = hCount - H_PRELOAD;
  assign hSyncN      = !((hCount >= HS_ON) && (hCount < HS_OFF));
  assign vSyncN      = !((vCount >= VS_ON) && (vCount < VS_OFF));
  assign frameStrobe = (hCount < H_STARTC);

  always_comb begin
    strb          = '0;
    strb.active   = inWin;
    strb.loadBase = pixEn && (hCount == '0) && (vCount == '0);
    // byte for pixel 8k is taken on the tick before that pixel is shown
    strb.loadByte = pixEn && lineVis && (hCount >= H_PRELOAD) &&
                    (hCount != H_LAST) && (hOff[2:0] == 3'd0);
    strb.shiftBit = pixEn && inWin && !strb.loadByte;
  end

  assert_h_range_R1: assert property (@(posedge clk) disable iff (rst)
    hCount <= H_LAST);
  assert_v_step_R2: assert property (@(posedge clk) disable iff (rst)
    (vCount != $past(vCount)) |-> ($past(hCount) == H_LAST && $past(pixEn)));
  assert_hsync_fall_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(hSyncN) |-> (hCount == HS_ON));
  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !pixEn |=> $stable(hCount) && $stable(vCount));
endmodule

// File: rtl/vga_scan_dp.sv
module vga_scan_dp
  import vga_scan_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  scanStrb_t         strb,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [7:0]        memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              pixOut
);
  logic [7:0] shiftReg;

  always_ff @(posedge clk) begin
    if (rst || strb.loadBase) begin
      memAddr <= baseAddr;
    end else if (strb.loadByte) begin
      memAddr <= memAddr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
    end else if (strb.loadByte) begin
      shiftReg <= memData;
    end else if (strb.shiftBit) begin
      shiftReg <= {shiftReg[6:0], 1'b0};
    end
  end

  assign pixOut = strb.active & shiftReg[7];

  assert_strb_excl_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.loadBase, strb.loadByte}));
  assert_addr_step_R7: assert property (@(posedge clk) disable iff (rst)
    strb.loadByte |=> (memAddr == $past(memAddr) + 1'b1));
endmodule

// File: rtl/vga_mono_scanout.sv
module vga_mono_scanout
  import vga_scan_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int H_ACT  = 640,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_ACT  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33,
  localparam int HW = $clog2(H_FP + H_SYNC + H_BP + H_ACT),
  localparam int VW = $clog2(V_FP + V_SYNC + V_BP + V_ACT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pixEn,
  input  logic [ADDR_W-1:0] baseAddr,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [7:0]        memData,
  output logic              hSyncN,
  output logic              vSyncN,
  output logic              frameStrobe,
  output logic              pixOut,
  output logic              activeVideo,
  output logic [HW-1:0]     hCount,
  output logic [VW-1:0]     vCount
);
  scanStrb_t strb;

  vga_scan_ctrl #(
    .H_ACT(H_ACT), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_ACT(V_ACT), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
  ) uCtrl (
    .clk(clk), .rst(rst), .pixEn(pixEn),
    .hCount(hCount), .vCount(vCount),
    .hSyncN(hSyncN), .vSyncN(vSyncN),
    .frameStrobe(frameStrobe), .strb(strb)
  );

  vga_scan_dp #(.ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rst(rst), .strb(strb),
    .baseAddr(baseAddr), .memData(memData),
    .memAddr(memAddr), .pixOut(pixOut)
  );

  assign activeVideo = strb.active;

  assert_blank_R8: assert property (@(posedge clk) disable iff (rst)
    !activeVideo |-> !pixOut);
endmodule

// File: tb/tb_vga_mono_scanout.sv
`timescale 1ns/1ps
module tb_vga_mono_scanout;
  // scaled instance: 32x5 visible, line 48, frame 10 lines
  localparam int SH_FP = 4, SH_SY = 6, SH_BP = 6, SH_ACT = 32;
  localparam int SV_FP = 2, SV_SY = 1, SV_BP = 2, SV_ACT = 5;
  localparam int SH_ST = SH_FP + SH_SY + SH_BP, SH_TOT = SH_ST + SH_ACT;
  localparam int SV_ST = SV_FP + SV_SY + SV_BP, SV_TOT = SV_ST + SV_ACT;
  localparam int RUN = 39000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1;
  logic pixEn = 1'b0;
  logic [15:0] baseAddr = 16'd0;
  logic [15:0] memAddr;
  logic [7:0]  memData;
  logic hSyncN, vSyncN, frameStrobe, pixOut, activeVideo;
  logic [5:0] hCount;
  logic [3:0] vCount;

  logic [15:0] memAddr2;
  logic hSyncN2, vSyncN2, frameStrobe2, pixOut2, activeVideo2;
  logic [9:0] hCount2, vCount2;

  logic [7:0] mem [0:255];

  vga_mono_scanout #(
    .ADDR_W(16), .H_ACT(SH_ACT), .H_FP(SH_FP), .H_SYNC(SH_SY), .H_BP(SH_BP),
    .V_ACT(SV_ACT), .V_FP(SV_FP), .V_SYNC(SV_SY), .V_BP(SV_BP)
  ) dut (
    .clk(clk), .rst(rst), .pixEn(pixEn), .baseAddr(baseAddr),
    .memAddr(memAddr), .memData(memData), .hSyncN(hSyncN), .vSyncN(vSyncN),
    .frameStrobe(frameStrobe), .pixOut(pixOut), .activeVideo(activeVideo),
    .hCount(hCount), .vCount(vCount)
  );

  vga_mono_scanout dutFull (
    .clk(clk), .rst(rst), .pixEn(1'b1), .baseAddr(16'd0),
    .memAddr(memAddr2), .memData(8'hA5), .hSyncN(hSyncN2), .vSyncN(vSyncN2),
    .frameStrobe(frameStrobe2), .pixOut(pixOut2), .activeVideo(activeVideo2),
    .hCount(hCount2), .vCount(vCount2)
  );

  always @(posedge clk) memData <= mem[memAddr[7:0]];

  int nChk = 0, nBad = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // independent reference model of the scaled instance
  int hE, vE, baseE, cyc2;
  always @(posedge clk) begin
    if (rst) begin
      hE <= 0; vE <= 0; baseE <= int'(baseAddr); cyc2 <= 0;
    end else begin
      cyc2 <= cyc2 + 1;
      if (pixEn) begin
        if (hE == 0 && vE == 0) baseE <= int'(baseAddr);
        if (hE == SH_TOT - 1) begin
          hE <= 0;
          vE <= (vE == SV_TOT - 1) ? 0 : vE + 1;
        end else hE <= hE + 1;
      end
    end
  end

  function automatic bit expPix(input int h, input int v, input int b);
    int p, l;
    if (h < SH_ST || v < SV_ST) return 1'b0;
    p = h - SH_ST;
    l = v - SV_ST;
    return mem[(b + l * (SH_ACT / 8) + p / 8) & 255][7 - (p % 8)];
  endfunction

  task automatic checkSmall();
    bit act;
    act = (hE >= SH_ST) && (vE >= SV_ST);
    chk(int'(hCount) == hE, "R1 hCount", int'(hCount), hE);
    chk(int'(vCount) == vE, "R2 vCount", int'(vCount), vE);
    chk(hSyncN == !(hE >= SH_FP && hE < SH_FP + SH_SY), "R3 hSyncN", hSyncN, !(hE >= SH_FP && hE < SH_FP + SH_SY));
    chk(vSyncN == !(vE >= SV_FP && vE < SV_FP + SV_SY), "R4 vSyncN", vSyncN, !(vE >= SV_FP && vE < SV_FP + SV_SY));
    chk(frameStrobe == (hE < SH_ST), "R5 frameStrobe", frameStrobe, hE < SH_ST);
    chk(activeVideo == act, "R6 activeVideo", activeVideo, act);
    if (act) chk(pixOut == expPix(hE, vE, baseE), "R7/R9 pixOut", pixOut, expPix(hE, vE, baseE));
    else     chk(pixOut == 1'b0, "R8 pixOut blank", pixOut, 0);
  endtask

  task automatic checkFull();
    int h, v, p;
    bit act, px;
    h = cyc2 % 800;
    v = (cyc2 / 800) % 525;
    act = (h >= 160) && (v >= 45);
    p = h - 160;
    px = act ? 8'hA5 >> (7 - (p % 8)) : 1'b0;
    chk(int'(hCount2) == h, "R1 full hCount", int'(hCount2), h);
    chk(int'(vCount2) == v, "R2 full vCount", int'(vCount2), v);
    chk(hSyncN2 == !(h >= 16 && h < 112), "R3 full hSyncN", hSyncN2, !(h >= 16 && h < 112));
    chk(vSyncN2 == !(v >= 10 && v < 12), "R4 full vSyncN", vSyncN2, !(v >= 10 && v < 12));
    chk(frameStrobe2 == (h < 160), "R5 full frameStrobe", frameStrobe2, h < 160);
    chk(activeVideo2 == act, "R6 full activeVideo", activeVideo2, act);
    chk(pixOut2 == px, "R7/R8 full pixOut", pixOut2, px);
  endtask

  initial begin
    int prevH, prevV;
    bit prevPix, prevEn;
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    prevEn = 1'b0; prevH = 0; prevV = 0; prevPix = 1'b0;
    for (int c = 0; c < RUN; c++) begin
      @(negedge clk);
      if (c == 37500) begin
        rst = 1'b1;
        baseAddr = 16'd77;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        pixEn = 1'b0;
        @(negedge clk);
        // R11: counters back at origin, address at the base input
        chk(hCount == 0 && vCount == 0, "R11 counters after reset", int'(hCount) + int'(vCount), 0);
        chk(memAddr == 16'd77, "R11 memAddr after reset", int'(memAddr), 77);
        prevEn = 1'b0; prevH = 0; prevV = 0; prevPix = 1'b0;
      end
      checkSmall();
      if (cyc2 < 37500) checkFull();
      if (!prevEn) begin
        // R10: no tick last cycle, so nothing moved
        chk(int'(hCount) == prevH && int'(vCount) == prevV, "R10 hold counters", int'(hCount), prevH);
        chk(pixOut == prevPix, "R10 hold pixOut", pixOut, prevPix);
      end
      prevH = int'(hCount); prevV = int'(vCount); prevPix = pixOut;
      pixEn = ($urandom % 4) != 0;
      prevEn = pixEn;
      // R9: base moves at random cycles, including frame-start ticks
      if (($urandom % 40) == 0) baseAddr = 16'($urandom % 200);
      if (hE == 0 && vE == 0 && ($urandom % 2) == 0) baseAddr = 16'($urandom % 200);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    #(5ns * 120000);
    if (!done) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule